// File: doc/BRIEF.md
# Token Ring Frame Receive Checker

This block watches the receive side of a token ring station. It takes a differential-Manchester line that has already been split into two half-bit samples per bit clock, together with a qualifier that says whether the receiver sees valid data. It classifies every bit cell as a data zero, a data one, or one of the two code-violation symbols (J and K). It hunts for the start delimiter. When it finds one, it pulses a start strobe so that downstream field parsers can begin work, and it then hands each decoded octet downstream as it completes.

Errors fall into two classes. An abort-class error ends reception at once: a stray code violation, a second start delimiter, or loss of the data qualifier in the middle of a frame. The block then pulses an abort strobe and goes back to hunting, and it reports no end of frame. A quality-class error lets the frame finish, but the block clears the good flag that goes with the end-of-frame strobe, so that the post-frame routine is not started. The quality checks are the frame check sequence residue, the error bit in the ending delimiter, and agreement between the duplicated address-recognised and frame-copied bits of the frame status octet.

Top module: `tr_rx_frame_checker`

## Requirements
- R1: While reset is low, and on the first clock after it, startPulse, dataValid, abortPulse, endPulse and frameGood are all 0.
- R2: Each bit cell is sampled at a rising clock edge. The J-K start delimiter is the symbol sequence J, K, 0, J, K, 0, 0, 0, in arrival order. When the last of these symbols is sampled while hunting, startPulse is high for exactly the one following cycle.
- R3: A data symbol has halfFirst different from halfSecond. It decodes to 1 when halfFirst equals the previous cell's halfSecond, and to 0 otherwise. Each octet of eight data symbols between the start and ending delimiters appears on dataByte, with the first-received bit in dataByte[7], and dataValid pulses for one cycle after its eighth symbol.
- R4: An octet of the frame body or the status field that holds a J or K symbol and is neither a start nor an ending delimiter gives a one-cycle abortPulse after its eighth symbol, and no endPulse follows.
- R5: A start delimiter that arrives in the octet slot of a frame body gives abortPulse and no second startPulse.
- R6: dataPresent sampled low during a frame body or status field gives abortPulse in the next cycle. dataPresent low while hunting gives no abortPulse.
- R7: After an abort, the block hunts again, and the next correct frame completes with endPulse and frameGood set.
- R8: The ending delimiter is J, K, 1, J, K, 1, I, E. The eight data symbols after it are the status octet. endPulse pulses for one cycle after its eighth symbol, and frameGood is high in that cycle only when every quality check passes.
- R9: The frame check sequence is CRC-32 (polynomial 0x04C11DB7, preset all ones, MSB-first bit order, appended complemented). Run over every body octet, this CRC must leave the residue 0xC704DD7B, or frameGood is 0.
- R10: The E symbol, which is the eighth symbol of the ending delimiter, must decode to 0, or frameGood is 0.
- R11: The status octet bits in arrival order are A, C, r, r, A, C, r, r (dataByte positions 7, 6, 3, 2 hold A, C, A, C). The two A bits must match and the two C bits must match, or frameGood is 0. The r bits have no effect.
- R12: Ending delimiter and status octets give no dataValid.
- R13: A cell with no mid-cell transition is J when halfFirst equals the previous halfSecond, and K otherwise. The J/K-swapped sequence K, J, 0, K, J, 0, 0, 0 is not a start delimiter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| dataPresent | input | 1 | Receiver has valid line data |
| halfFirst | input | 1 | First half-bit sample of the cell |
| halfSecond | input | 1 | Second half-bit sample of the cell |
| startPulse | output | 1 | Start delimiter found |
| dataValid | output | 1 | dataByte holds a new body octet |
| dataByte | output | 8 | Decoded body octet, first bit in MSB |
| abortPulse | output | 1 | Reception cancelled |
| endPulse | output | 1 | Frame completed through status octet |
| frameGood | output | 1 | Qualifies endPulse: all quality checks passed |

## Verification
On every cycle, the bound checker enforces the strobe discipline: at most one of the start, abort and end strobes at a time, frameGood only alongside endPulse, and no back-to-back start pulses. It also tracks frame occupancy from the strobes, which lets it enforce that a qualifier drop inside a frame is followed by an abort, that a drop while hunting is not, and that octets and end or abort strobes only come from inside a frame. Only the bench's scenarios can show the decoded octet values, the CRC residue verdict, the E-bit and status-bit verdicts, the rejection of a polarity-swapped delimiter, and the exact cycle on which each strobe appears relative to the last symbol driven.

// File: rtl/tr_rx_pkg.sv
package tr_rx_pkg;
  localparam int OCT_SYMS = 8;
  localparam int CNT_W = $clog2(OCT_SYMS);

  typedef enum logic [1:0] {
    SYM_ZERO = 2'd0,
    SYM_ONE  = 2'd1,
    SYM_J    = 2'd2,
    SYM_K    = 2'd3
  } symT;

  typedef enum logic [1:0] {
    OCT_DATA,
    OCT_START,
    OCT_END,
    OCT_BAD
  } octT;

  typedef struct packed {
    logic shift;
    logic clearWin;
    logic crcInit;
    logic byteAccept;
    logic edCapture;
  } strobeT;
endpackage

// File: rtl/tr_rx_symbol_path.sv
module tr_rx_symbol_path
  import tr_rx_pkg::*;
#(
  parameter int CRC_W = 32,
  parameter logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7,
  parameter logic [CRC_W-1:0] CRC_RESIDUE = 32'hC704DD7B
) (
  input  logic clk,
  input  logic rstN,
  input  logic halfFirst,
  input  logic halfSecond,
  input  strobeT stb,
  output octT  octetKind,
  output logic statusOk,
  output logic [OCT_SYMS-1:0] dataByte,
  output logic dataValid
);
  // Window slot 0 is the newest symbol, slot OCT_SYMS-1 the oldest.
  localparam int A_FIRST = OCT_SYMS - 1;
  localparam int C_FIRST = OCT_SYMS - 2;
  localparam int A_SECOND = OCT_SYMS - 5;
  localparam int C_SECOND = OCT_SYMS - 6;

  logic lastHalf;
  symT newSym;
  symT win [OCT_SYMS];
  symT winNext [OCT_SYMS];
  logic [OCT_SYMS-1:0] isData;
  logic [OCT_SYMS-1:0] octBits;
  logic [CRC_W-1:0] crcReg;
  logic eReg;
  logic isStart, isEnd;

  function automatic logic [CRC_W-1:0] crcStep(input logic [CRC_W-1:0] seed,
                                               input logic [OCT_SYMS-1:0] octet);
    logic [CRC_W-1:0] acc;
    logic fb;
    acc = seed;
    for (int k = OCT_SYMS - 1; k >= 0; k--) begin
      fb = acc[CRC_W-1] ^ octet[k];
      acc = {acc[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    return acc;
  endfunction

  // Cell classification against the level left by the previous cell.
  always_comb begin
    if (halfFirst != halfSecond)
      newSym = (halfFirst == lastHalf) ? SYM_ONE : SYM_ZERO;
    else
      newSym = (halfFirst == lastHalf) ? SYM_J : SYM_K;
  end

  assign winNext[0] = newSym;
  for (genvar i = 0; i < OCT_SYMS; i++) begin : g_slot
    if (i > 0) begin : g_link
      assign winNext[i] = win[i-1];
    end
    assign isData[i]  = (winNext[i] == SYM_ZERO) || (winNext[i] == SYM_ONE);
    assign octBits[i] = (winNext[i] == SYM_ONE);
  end

  always_comb begin
    isStart = (winNext[7] == SYM_J) && (winNext[6] == SYM_K) && (winNext[5] == SYM_ZERO) &&
              (winNext[4] == SYM_J) && (winNext[3] == SYM_K) && (winNext[2] == SYM_ZERO) &&
              (winNext[1] == SYM_ZERO) && (winNext[0] == SYM_ZERO);
    isEnd   = (winNext[7] == SYM_J) && (winNext[6] == SYM_K) && (winNext[5] == SYM_ONE) &&
              (winNext[4] == SYM_J) && (winNext[3] == SYM_K) && (winNext[2] == SYM_ONE) &&
              isData[1] && isData[0];
    if (&isData)      octetKind = OCT_DATA;
    else if (isStart) octetKind = OCT_START;
    else if (isEnd)   octetKind = OCT_END;
    else              octetKind = OCT_BAD;
  end

  assign statusOk = (crcReg == CRC_RESIDUE) && !eReg &&
                    (octBits[A_FIRST] == octBits[A_SECOND]) &&
                    (octBits[C_FIRST] == octBits[C_SECOND]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastHalf <= 1'b0;
      for (int i = 0; i < OCT_SYMS; i++) win[i] <= SYM_ZERO;
      crcReg <= '1;
      eReg <= 1'b0;
      dataByte <= '0;
      dataValid <= 1'b0;
    end else begin
      lastHalf <= halfSecond;
      if (stb.clearWin) begin
        for (int i = 0; i < OCT_SYMS; i++) win[i] <= SYM_ZERO;
      end else if (stb.shift) begin
        for (int i = 0; i < OCT_SYMS; i++) win[i] <= winNext[i];
      end
      if (stb.crcInit) crcReg <= '1;
      else if (stb.byteAccept) crcReg <= crcStep(crcReg, octBits);
      if (stb.edCapture) eReg <= octBits[0];
      dataValid <= stb.byteAccept;
      if (stb.byteAccept) dataByte <= octBits;
    end
  end
endmodule

// File: rtl/tr_rx_frame_ctrl.sv
module tr_rx_frame_ctrl
  import tr_rx_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic dataPresent,
  input  octT  octetKind,
  input  logic statusOk,
  output strobeT stb,
  output logic startPulse,
  output logic abortPulse,
  output logic endPulse,
  output logic frameGood
);
  localparam logic [CNT_W-1:0] LAST_SYM = CNT_W'(OCT_SYMS - 1);

  typedef enum logic [1:0] {ST_HUNT, ST_BODY, ST_STATUS} stateT;

  stateT state, stateNext;
  logic [CNT_W-1:0] symCnt, symCntNext;
  logic startNow, abortNow, endNow;

  always_comb begin
    stb = '0;
    stb.shift = dataPresent;
    stb.clearWin = !dataPresent;
    stateNext = state;
    symCntNext = symCnt;
    startNow = 1'b0;
    abortNow = 1'b0;
    endNow = 1'b0;
    case (state)
      ST_HUNT: begin
        if (dataPresent && octetKind == OCT_START) begin
          stateNext = ST_BODY;
          symCntNext = '0;
          stb.crcInit = 1'b1;
          startNow = 1'b1;
        end
      end
      ST_BODY: begin
        if (!dataPresent) begin
          abortNow = 1'b1;
          stateNext = ST_HUNT;
        end else if (symCnt == LAST_SYM) begin
          symCntNext = '0;
          case (octetKind)
            OCT_DATA: stb.byteAccept = 1'b1;
            OCT_END: begin
              stb.edCapture = 1'b1;
              stateNext = ST_STATUS;
            end
            default: begin
              abortNow = 1'b1;
              stateNext = ST_HUNT;
            end
          endcase
        end else begin
          symCntNext = symCnt + 1'b1;
        end
      end
      ST_STATUS: begin
        if (!dataPresent) begin
          abortNow = 1'b1;
          stateNext = ST_HUNT;
        end else if (symCnt == LAST_SYM) begin
          symCntNext = '0;
          stateNext = ST_HUNT;
          if (octetKind == OCT_DATA) endNow = 1'b1;
          else abortNow = 1'b1;
        end else begin
          symCntNext = symCnt + 1'b1;
        end
      end
      default: stateNext = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_HUNT;
      symCnt <= '0;
      startPulse <= 1'b0;
      abortPulse <= 1'b0;
      endPulse <= 1'b0;
      frameGood <= 1'b0;
    end else begin
      state <= stateNext;
      symCnt <= symCntNext;
      startPulse <= startNow;
      abortPulse <= abortNow;
      endPulse <= endNow;
      frameGood <= endNow && statusOk;
    end
  end
endmodule

// File: rtl/tr_rx_frame_checker.sv
module tr_rx_frame_checker
  import tr_rx_pkg::*;
#(
  parameter int CRC_W = 32,
  parameter logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7,
  parameter logic [CRC_W-1:0] CRC_RESIDUE = 32'hC704DD7B
) (
  input  logic clk,
  input  logic rstN,
  input  logic dataPresent,
  input  logic halfFirst,
  input  logic halfSecond,
  output logic startPulse,
  output logic dataValid,
  output logic [OCT_SYMS-1:0] dataByte,
  output logic abortPulse,
  output logic endPulse,
  output logic frameGood
);
  strobeT stb;
  octT octetKind;
  logic statusOk;

  tr_rx_symbol_path #(
    .CRC_W(CRC_W), .CRC_POLY(CRC_POLY), .CRC_RESIDUE(CRC_RESIDUE)
  ) u_path (
    .clk(clk), .rstN(rstN), .halfFirst(halfFirst), .halfSecond(halfSecond),
    .stb(stb), .octetKind(octetKind), .statusOk(statusOk),
    .dataByte(dataByte), .dataValid(dataValid)
  );

  tr_rx_frame_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .dataPresent(dataPresent), .octetKind(octetKind),
    .statusOk(statusOk), .stb(stb), .startPulse(startPulse),
    .abortPulse(abortPulse), .endPulse(endPulse), .frameGood(frameGood)
  );
endmodule

// File: rtl/tr_rx_frame_checker_sva.sv
module tr_rx_frame_checker_sva (
  input logic clk,
  input logic rstN,
  input logic dataPresent,
  input logic startPulse,
  input logic dataValid,
  input logic abortPulse,
  input logic endPulse,
  input logic frameGood
);
  // Frame occupancy rebuilt from the strobes alone.
  logic busyQ, busy;
  assign busy = startPulse | (busyQ & !abortPulse & !endPulse);
  always_ff @(posedge clk) begin
    if (!rstN) busyQ <= 1'b0;
    else busyQ <= busy;
  end

  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({startPulse, abortPulse, endPulse}));
  assert_start_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> !startPulse);
  assert_good_qualified_R8: assert property (@(posedge clk) disable iff (!rstN)
    frameGood |-> endPulse);
  assert_drop_aborts_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !dataPresent) |=> abortPulse);
  assert_hunt_ignores_drop_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !dataPresent) |=> !abortPulse);
  assert_octet_in_frame_R12: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> busy);
  assert_end_from_frame_R8: assert property (@(posedge clk) disable iff (!rstN)
    (endPulse || abortPulse) |-> busyQ);
endmodule

bind tr_rx_frame_checker tr_rx_frame_checker_sva u_sva (
  .clk(clk), .rstN(rstN), .dataPresent(dataPresent), .startPulse(startPulse),
  .dataValid(dataValid), .abortPulse(abortPulse), .endPulse(endPulse),
  .frameGood(frameGood)
);

// File: tb/tb_tr_rx_frame_checker.sv
module tb_tr_rx_frame_checker;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dataPresent = 1'b0;
  logic halfFirst = 1'b0;
  logic halfSecond = 1'b0;
  logic startPulse, dataValid, abortPulse, endPulse, frameGood;
  logic [7:0] dataByte;

  tr_rx_frame_checker dut (
    .clk(clk), .rstN(rstN), .dataPresent(dataPresent), .halfFirst(halfFirst),
    .halfSecond(halfSecond), .startPulse(startPulse), .dataValid(dataValid),
    .dataByte(dataByte), .abortPulse(abortPulse), .endPulse(endPulse),
    .frameGood(frameGood)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic level = 1'b0;
  int lastDrive = 0;

  // Monitor of strobes, sampled away from the active edge.
  int startCnt, abortCnt, endCnt, byteCnt, startAt, abortAt, endAt;
  logic goodSeen;
  logic [7:0] rxBytes [64];
  logic [7:0] txBytes [64];
  int txCount;

  always @(negedge clk) begin
    if (startPulse) begin startCnt++; startAt = cyc; end
    if (abortPulse) begin abortCnt++; abortAt = cyc; end
    if (endPulse) begin endCnt++; endAt = cyc; goodSeen = frameGood; end
    if (dataValid && byteCnt < 64) begin rxBytes[byteCnt] = dataByte; byteCnt++; end
  end

  task automatic clearMon();
    startCnt = 0; abortCnt = 0; endCnt = 0; byteCnt = 0;
    startAt = -1; abortAt = -1; endAt = -1; goodSeen = 1'b0; txCount = 0;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic f, input logic s);
    @(negedge clk);
    halfFirst = f; halfSecond = s; dataPresent = 1'b1;
    lastDrive = cyc; level = s;
  endtask

  task automatic sendBit(input logic b);
    logic f;
    f = b ? level : ~level;
    drive(f, ~f);
  endtask
  task automatic sendJ(); drive(level, level); endtask
  task automatic sendK(); drive(~level, ~level); endtask

  task automatic sendSd();
    sendJ(); sendK(); sendBit(0); sendJ(); sendK(); sendBit(0); sendBit(0); sendBit(0);
  endtask
  task automatic sendEd(input logic e);
    sendJ(); sendK(); sendBit(1); sendJ(); sendK(); sendBit(1); sendBit(0); sendBit(e);
  endtask
  task automatic sendByte(input logic [7:0] b);
    for (int k = 7; k >= 0; k--) sendBit(b[k]);
  endtask
  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      dataPresent = 1'b0; lastDrive = cyc;
    end
  endtask

  function automatic logic [31:0] crcAdd(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c;
    for (int k = 7; k >= 0; k--) begin
      if (r[31] ^ b[k]) r = (r << 1) ^ 32'h04C11DB7;
      else r = r << 1;
    end
    return r;
  endfunction

  int sdCyc, fsCyc;
  task automatic sendFrame(input int len, input logic [7:0] seed, input bit badCrc,
                           input logic e, input logic [7:0] fs);
    logic [31:0] c, fcs;
    c = 32'hFFFFFFFF;
    sendSd(); sdCyc = lastDrive;
    for (int i = 0; i < len; i++) begin
      txBytes[txCount] = seed + 8'(i * 37);
      c = crcAdd(c, txBytes[txCount]);
      sendByte(txBytes[txCount]);
      txCount++;
    end
    fcs = ~c;
    if (badCrc) fcs[0] = ~fcs[0];
    for (int i = 3; i >= 0; i--) begin
      txBytes[txCount] = fcs[i*8 +: 8];
      sendByte(txBytes[txCount]);
      txCount++;
    end
    sendEd(e);
    sendByte(fs); fsCyc = lastDrive;
    idle(3);
  endtask

  // {len[22:19], seed[18:11], badCrc[10], eBit[9], fs[8:1], expectGood[0]}
  localparam logic [22:0] VEC [8] = '{
    {4'd3, 8'h10, 1'b0, 1'b0, 8'h00, 1'b1},
    {4'd5, 8'hA5, 1'b0, 1'b0, 8'hCC, 1'b1},
    {4'd1, 8'h3C, 1'b1, 1'b0, 8'h00, 1'b0},
    {4'd4, 8'h77, 1'b0, 1'b1, 8'h00, 1'b0},
    {4'd2, 8'h01, 1'b0, 1'b0, 8'h80, 1'b0},
    {4'd2, 8'hF0, 1'b0, 1'b0, 8'h40, 1'b0},
    {4'd0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1},
    {4'd6, 8'h5A, 1'b0, 1'b0, 8'h33, 1'b1}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int v, mism;
    clearMon();
    repeat (3) @(negedge clk);
    chk({startPulse, dataValid, abortPulse, endPulse, frameGood} == 5'b0,
        "R1 outputs in reset", {startPulse, dataValid, abortPulse, endPulse, frameGood}, 0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    chk({startPulse, dataValid, abortPulse, endPulse, frameGood} == 5'b0,
        "R1 outputs after reset", {startPulse, dataValid, abortPulse, endPulse, frameGood}, 0);
    idle(2);

    // Table of frames walked by one loop.
    for (int t = 0; t < 8; t++) begin
      clearMon();
      sendFrame(int'(VEC[t][22:19]), VEC[t][18:11], VEC[t][10], VEC[t][9], VEC[t][8:1]);
      chk(startCnt == 1, $sformatf("R2 start count vec%0d", t), startCnt, 1);
      chk(startAt == sdCyc + 1, $sformatf("R2 start cycle vec%0d", t), startAt, sdCyc + 1);
      chk(abortCnt == 0, $sformatf("R4 no abort vec%0d", t), abortCnt, 0);
      chk(endCnt == 1, $sformatf("R8 end count vec%0d", t), endCnt, 1);
      chk(endAt == fsCyc + 1, $sformatf("R8 end cycle vec%0d", t), endAt, fsCyc + 1);
      chk(goodSeen == VEC[t][0], $sformatf("R9 R10 R11 good flag vec%0d", t),
          int'(goodSeen), int'(VEC[t][0]));
      chk(byteCnt == txCount, $sformatf("R12 octet count vec%0d", t), byteCnt, txCount);
      mism = 0;
      for (int i = 0; i < txCount; i++) if (rxBytes[i] != txBytes[i]) mism++;
      chk(mism == 0, $sformatf("R3 octet values vec%0d", t), mism, 0);
    end

    // R13: polarity-swapped delimiter is not a start.
    clearMon();
    sendK(); sendJ(); sendBit(0); sendK(); sendJ(); sendBit(0); sendBit(0); sendBit(0);
    idle(3);
    chk(startCnt == 0, "R13 swapped delimiter", startCnt, 0);

    // R4: stray code violation inside the body.
    clearMon();
    sendSd(); sendByte(8'h12);
    sendBit(0); sendBit(0); sendJ(); sendK(); sendBit(0); sendBit(0); sendBit(0); sendBit(0);
    v = lastDrive; idle(3);
    chk(abortCnt == 1, "R4 violation abort", abortCnt, 1);
    chk(abortAt == v + 1, "R4 abort cycle", abortAt, v + 1);
    chk(endCnt == 0, "R4 no end", endCnt, 0);
    chk(byteCnt == 1 && rxBytes[0] == 8'h12, "R3 octet before violation", byteCnt, 1);

    // R5: second start delimiter inside the body.
    clearMon();
    sendSd(); sendByte(8'h34); sendSd();
    v = lastDrive; idle(3);
    chk(abortCnt == 1 && abortAt == v + 1, "R5 second start abort", abortAt, v + 1);
    chk(startCnt == 1, "R5 no second start", startCnt, 1);
    chk(endCnt == 0, "R5 no end", endCnt, 0);

    // R6: qualifier drop inside the body.
    clearMon();
    sendSd(); sendByte(8'h56); sendBit(1); sendBit(0); sendBit(1);
    idle(1); v = lastDrive; idle(3);
    chk(abortCnt == 1 && abortAt == v + 1, "R6 drop abort cycle", abortAt, v + 1);
    chk(endCnt == 0, "R6 no end", endCnt, 0);

    // R6: qualifier drop inside the status field.
    clearMon();
    sendSd(); sendByte(8'h9A); sendEd(1'b0); sendBit(0); sendBit(0);
    idle(1); v = lastDrive; idle(3);
    chk(abortCnt == 1 && abortAt == v + 1, "R6 status drop abort", abortAt, v + 1);
    chk(endCnt == 0, "R6 status drop no end", endCnt, 0);

    // R6: qualifier low while hunting.
    clearMon();
    idle(6);
    chk(abortCnt == 0, "R6 hunt ignores drop", abortCnt, 0);

    // R4: code violation inside the status octet.
    clearMon();
    sendSd(); sendByte(8'hBE); sendEd(1'b0);
    sendBit(0); sendBit(0); sendJ(); sendK(); sendBit(0); sendBit(0); sendBit(0); sendBit(0);
    v = lastDrive; idle(3);
    chk(abortCnt == 1 && abortAt == v + 1, "R4 status violation abort", abortAt, v + 1);
    chk(endCnt == 0, "R4 status violation no end", endCnt, 0);

    // R7: good frame right after an abort.
    clearMon();
    sendFrame(3, 8'h21, 1'b0, 1'b0, 8'h88);
    chk(endCnt == 1 && goodSeen == 1'b1, "R7 recovery frame good", int'(goodSeen), 1);
    chk(abortCnt == 0, "R7 recovery no abort", abortCnt, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule